// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block receives low-speed USB packets from D+ and D- line inputs that are already synchronised to its sample clock. It expects about eleven sample clocks per bit. It waits for the bus to idle and then hunts for the sync field. It locks only when two K bits arrive in a row. After lock it decodes NRZI, drops stuffed bits and assembles each byte LSB first. Each completed byte goes out on a simple write port (strobe, address, data) into an external byte buffer.

The sample phase is re-centred on every observed D- transition, so a sender clock that is about one percent off still decodes correctly. A packet ends on SE0 and reports its byte count with a one-cycle done pulse. A packet longer than the buffer is aborted with an overflow pulse. A sync hunt that stalls reports a sync error. CRC, PID decoding and the analog front end sit outside the block.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset all pulse outputs (`wr_en_o`, `done_o`, `overflow_o`, `sync_err_o`) are low and `byte_cnt_o` is 0.
- R2: Line state J is `dm_i`=1/`dp_i`=0 and state K is `dm_i`=0/`dp_i`=1. The receiver first waits for J, then for a K. On that K it arms a check one bit later, at mid-bit. It locks only if that check sees K again; otherwise it hunts for the next K.
- R3: If no K appears within `SYNC_WAIT` clocks after a failed check, `sync_err_o` pulses for one clock and the receiver returns to waiting for J.
- R4: After lock, each data bit is decoded by NRZI. A bit is 1 when its D- level equals the previous bit's level and 0 when it differs. The first data bit is compared against K.
- R5: After six consecutive decoded 1s, the next bit is discarded. The final K of the sync counts as the first of those 1s.
- R6: Bytes are assembled LSB first. Each byte is written with a one-cycle `wr_en_o`, a `wr_addr_o` that counts up from 0 within the packet, and `byte_cnt_o` equal to `wr_addr_o`+1 in that cycle.
- R7: SE0 (both lines low) is tested once per byte, at the sample that would supply bit 1 of a byte. When found, `done_o` pulses for one clock with `byte_cnt_o` equal to the number of bytes written. A packet with no data byte reports 0.
- R8: When byte number `BUF_DEPTH`+1 completes, it is not written and `overflow_o` pulses instead of `done_o`. The rest of the packet up to SE0 is ignored, and the next packet is received normally.
- R9: Every D- transition after the first K restarts the bit-phase counter. A data bit is sampled `OVS`/2 clocks after the transition that started it, and again every `OVS` clocks while the level holds.
- R10: With that re-centring, packets whose bits are sometimes one clock longer or one clock shorter than `OVS` decode exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, `OVS` per bit |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dp_i | input | 1 | Synchronised D+ level |
| dm_i | input | 1 | Synchronised D- level |
| wr_en_o | output | 1 | Byte write strobe |
| wr_addr_o | output | $clog2(BUF_DEPTH) | Buffer address of the byte |
| wr_data_o | output | 8 | Decoded byte |
| done_o | output | 1 | End of packet pulse |
| byte_cnt_o | output | $clog2(BUF_DEPTH+1) | Bytes received in the current packet |
| overflow_o | output | 1 | Packet exceeded buffer pulse |
| sync_err_o | output | 1 | Sync hunt timed out pulse |

## Verification
The stimulus covers several packet shapes, each aimed at a different behaviour:
- Mixed bytes with many transitions test NRZI polarity and LSB-first order.
- Runs of 0xFF force stuffed bits; any off-by-one in the run counter shows up as shifted data.
- An empty packet places SE0 on the very first bit-1 slot.
- Packets with bits one clock long or short separate true phase re-centring from free-running sampling.
- A lone K followed by idle exercises the hunt timeout.
- An over-long packet shows that the extra byte is withheld and that reception recovers on the following packet.

// File: rtl/usb_ls_rx_pkg.sv
`timescale 1ns/1ps
package usb_ls_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_CHECK, ST_HUNT, ST_RX, ST_DRAIN
  } rx_state_e;

  localparam int unsigned STUFF_RUN = 6;
endpackage

// File: rtl/usb_ls_phase.sv
`timescale 1ns/1ps
module usb_ls_phase #(
  parameter int unsigned OVS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dm_i,
  input  logic restart_i,
  input  logic track_i,
  output logic strobe_o
);
  localparam int unsigned PW   = $clog2(OVS);
  localparam int unsigned HALF = OVS / 2;

  logic [PW-1:0] ph_q;
  logic          dm_q;
  logic          realign;

  assign realign  = restart_i | (track_i & (dm_i != dm_q));
  assign strobe_o = (ph_q == PW'(HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
      dm_q <= 1'b1;
    end else begin
      dm_q <= dm_i;
      // cycle of the transition is position 0
      if (realign)                   ph_q <= PW'(1);
      else if (ph_q == PW'(OVS - 1)) ph_q <= '0;
      else                           ph_q <= ph_q + PW'(1);
    end
  end
endmodule

// File: rtl/usb_ls_decode.sv
`timescale 1ns/1ps
module usb_ls_decode
  import usb_ls_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       step_i,
  input  logic       lvl_i,
  output logic [2:0] bit_idx_o,
  output logic       byte_done_o,
  output logic [7:0] byte_o
);
  logic       prev_q;
  logic [2:0] ones_q;
  logic [2:0] idx_q;
  logic [7:0] sh_q;
  logic       bit_v;
  logic       stuffed;

  assign bit_v       = (lvl_i == prev_q);
  assign stuffed     = (ones_q == 3'(STUFF_RUN));
  assign bit_idx_o   = idx_q;
  assign byte_done_o = step_i & ~stuffed & (idx_q == 3'd7);
  assign byte_o      = {bit_v, sh_q[7:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      ones_q <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else if (init_i) begin
      prev_q <= 1'b0;      // last sync bit was K
      ones_q <= 3'd1;      // and decoded as a 1
      idx_q  <= '0;
    end else if (step_i) begin
      prev_q <= lvl_i;
      if (stuffed) begin
        ones_q <= '0;
      end else begin
        ones_q <= bit_v ? ones_q + 3'd1 : 3'd0;
        sh_q   <= {bit_v, sh_q[7:1]};
        idx_q  <= idx_q + 3'd1;
      end
    end
  end
endmodule

// File: rtl/usb_ls_rx.sv
`timescale 1ns/1ps
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter  int unsigned OVS       = 11,
  parameter  int unsigned BUF_DEPTH = 8,
  parameter  int unsigned SYNC_WAIT = 11,
  localparam int unsigned AW        = $clog2(BUF_DEPTH),
  localparam int unsigned CW        = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dp_i,
  input  logic          dm_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          done_o,
  output logic [CW-1:0] byte_cnt_o,
  output logic          overflow_o,
  output logic          sync_err_o
);
  localparam int unsigned TW = $clog2(SYNC_WAIT + 1);

  rx_state_e     state_q, state_d;
  logic          skip_q;
  logic [TW-1:0] tmr_q;
  logic [CW-1:0] cnt_q;

  logic is_j, is_k, is_se0;
  logic strobe, restart, track;
  logic init, step, eop, full, timeout;
  logic [2:0] bit_idx;
  logic       byte_done;
  logic [7:0] byte_v;

  assign is_j   =  dm_i & ~dp_i;
  assign is_k   = ~dm_i &  dp_i;
  assign is_se0 = ~dm_i & ~dp_i;

  assign restart = ((state_q == ST_ARMED) | (state_q == ST_HUNT)) & is_k;
  assign track   = (state_q == ST_CHECK) | (state_q == ST_RX);
  assign init    = (state_q == ST_CHECK) & strobe & ~skip_q & is_k;
  assign eop     = (state_q == ST_RX) & strobe & (bit_idx == 3'd1) & is_se0;
  assign step    = (state_q == ST_RX) & strobe & ~eop;
  assign full    = (cnt_q == CW'(BUF_DEPTH));
  assign timeout = (tmr_q == TW'(SYNC_WAIT - 1));

  usb_ls_phase #(.OVS(OVS)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dm_i      (dm_i),
    .restart_i (restart),
    .track_i   (track),
    .strobe_o  (strobe)
  );

  usb_ls_decode u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init),
    .step_i      (step),
    .lvl_i       (dm_i),
    .bit_idx_o   (bit_idx),
    .byte_done_o (byte_done),
    .byte_o      (byte_v)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (is_j) state_d = ST_ARMED;
      ST_ARMED: if (is_k) state_d = ST_CHECK;
      ST_CHECK: if (strobe && !skip_q) state_d = is_k ? ST_RX : ST_HUNT;
      ST_HUNT: begin
        if (is_k)         state_d = ST_CHECK;
        else if (timeout) state_d = ST_IDLE;
      end
      ST_RX: begin
        if (eop)                    state_d = ST_IDLE;
        else if (byte_done && full) state_d = ST_DRAIN;
      end
      ST_DRAIN: if (is_se0) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      skip_q     <= 1'b0;
      tmr_q      <= '0;
      cnt_q      <= '0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      done_o     <= 1'b0;
      overflow_o <= 1'b0;
      sync_err_o <= 1'b0;
    end else begin
      state_q <= state_d;
      // first mid-bit after the K edge is the edge bit itself: skip it
      if (restart)                              skip_q <= 1'b1;
      else if (state_q == ST_CHECK && strobe)   skip_q <= 1'b0;
      tmr_q <= (state_q == ST_HUNT) ? tmr_q + TW'(1) : '0;

      if (init)                   cnt_q <= '0;
      else if (byte_done && !full) cnt_q <= cnt_q + CW'(1);

      wr_en_o    <= byte_done & ~full;
      if (byte_done && !full) begin
        wr_addr_o <= cnt_q[AW-1:0];
        wr_data_o <= byte_v;
      end
      done_o     <= eop;
      overflow_o <= byte_done & full;
      sync_err_o <= (state_q == ST_HUNT) & ~is_k & timeout;
    end
  end

  assign byte_cnt_o = cnt_q;
endmodule

// File: rtl/usb_ls_rx_chk.sv
`timescale 1ns/1ps
module usb_ls_rx_chk #(
  parameter  int unsigned BUF_DEPTH = 8,
  localparam int unsigned AW        = $clog2(BUF_DEPTH),
  localparam int unsigned CW        = $clog2(BUF_DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dp_i,
  input logic          dm_i,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o,
  input logic          done_o,
  input logic [CW-1:0] byte_cnt_o,
  input logic          overflow_o,
  input logic          sync_err_o
);
  AST_WR_CNT_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> byte_cnt_o == CW'(wr_addr_o) + CW'(1)); // R6

  AST_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> CW'(wr_addr_o) < CW'(BUF_DEPTH)); // R8

  AST_DONE_AFTER_SE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(!dp_i && !dm_i)); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_OVF_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> byte_cnt_o == CW'(BUF_DEPTH)); // R8

  AST_SERR_NO_K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_o |-> $past(!(dp_i && !dm_i))); // R3

  AST_EVENTS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_o, done_o, overflow_o, sync_err_o})); // R7
endmodule

bind usb_ls_rx usb_ls_rx_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dp_i       (dp_i),
  .dm_i       (dm_i),
  .wr_en_o    (wr_en_o),
  .wr_addr_o  (wr_addr_o),
  .done_o     (done_o),
  .byte_cnt_o (byte_cnt_o),
  .overflow_o (overflow_o),
  .sync_err_o (sync_err_o)
);

// File: tb/usb_ls_rx_tb.sv
`timescale 1ns/1ps
module usb_ls_rx_tb;
  localparam int OVS   = 11;
  localparam int DEPTH = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  localparam int K_WR = 0, K_DONE = 1, K_OVF = 2, K_SERR = 3;
  localparam int L_J = 0, L_K = 1, L_SE0 = 2;

  typedef struct {
    int    kind;
    int    a;
    int    b;
    string req;
  } exp_t;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b0, dm = 1'b1;
  logic          wr_en, done, ovf, serr;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [CW-1:0] byte_cnt;

  int   n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  usb_ls_rx #(.OVS(OVS), .BUF_DEPTH(DEPTH), .SYNC_WAIT(11)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .done_o(done), .byte_cnt_o(byte_cnt), .overflow_o(ovf), .sync_err_o(serr)
  );

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input int kind, input int a, input int b, input string req);
    exp_t e;
    e.kind = kind; e.a = a; e.b = b; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic observe(input int kind, input int a, input int b);
    exp_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL unexpected event actual kind=%0d a=%0d b=%0d expected none", kind, a, b);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.a != a || e.b != b) begin
        n_fail++;
        $display("FAIL %s actual kind=%0d a=%0d b=%0d expected kind=%0d a=%0d b=%0d",
                 e.req, kind, a, b, e.kind, e.a, e.b);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (wr_en) observe(K_WR, int'(wr_addr), int'(wr_data));
      if (done)  observe(K_DONE, int'(byte_cnt), 0);
      if (ovf)   observe(K_OVF, int'(byte_cnt), 0);
      if (serr)  observe(K_SERR, 0, 0);
    end
  end

  task automatic line(input int st, input int len);
    repeat (len) begin
      @(posedge clk); #1;
      dm = (st == L_J);
      dp = (st == L_K);
    end
  endtask

  // driver: computes the expected events, then drives the line
  task automatic send_pkt(input bq_t d, input int drift, input string req);
    int bi = 0;
    int cur = L_K;
    int ones = 1;
    int n = d.size();
    int sync_lv[8] = '{L_K, L_J, L_K, L_J, L_K, L_J, L_K, L_K};
    for (int i = 0; i < n; i++)
      if (i < DEPTH) push(K_WR, i, int'(d[i]), req);
    if (n > DEPTH) push(K_OVF, DEPTH, 0, {req, " R8"});
    else           push(K_DONE, n, 0, {req, " R7"});
    line(L_J, 3 * OVS);
    for (int i = 0; i < 8; i++) begin
      line(sync_lv[i], OVS + ((drift != 0 && bi % 8 == 7) ? drift : 0));
      bi++;
    end
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (d[i][b]) ones++;
        else begin ones = 0; cur = (cur == L_K) ? L_J : L_K; end
        line(cur, OVS + ((drift != 0 && bi % 8 == 7) ? drift : 0));
        bi++;
        if (ones == 6) begin
          ones = 0; cur = (cur == L_K) ? L_J : L_K;
          line(cur, OVS + ((drift != 0 && bi % 8 == 7) ? drift : 0));
          bi++;
        end
      end
    end
    line(L_SE0, 2 * OVS);
    line(L_J, 3 * OVS);
  endtask

  // watchdog
  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 wr_en", int'(wr_en), 0);
    check("R1 done", int'(done), 0);
    check("R1 overflow", int'(ovf), 0);
    check("R1 sync_err", int'(serr), 0);
    check("R1 byte_cnt", int'(byte_cnt), 0);

    send_pkt('{8'hA5, 8'h3C, 8'h01}, 0, "R2 R4 R6 basic");
    send_pkt('{8'hFF, 8'hFF, 8'h7E}, 0, "R5 stuffing");
    send_pkt('{}, 0, "R7 empty");
    send_pkt('{8'hFF, 8'h00, 8'h55, 8'hC3, 8'h80}, 1, "R9 R10 slow");
    send_pkt('{8'hFF, 8'h00, 8'h55, 8'hC3, 8'h80}, -1, "R9 R10 fast");

    // R3 lone K then idle J
    push(K_SERR, 0, 0, "R3 hunt timeout");
    line(L_J, 3 * OVS);
    line(L_K, OVS);
    line(L_J, 6 * OVS);

    send_pkt('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A},
             0, "R8 overflow");
    send_pkt('{8'h12, 8'h34}, 0, "R8 recovery");

    repeat (50) @(posedge clk);
    @(negedge clk);
    check("R6 R7 all expected events seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule